// File: doc/BRIEF.md
# Vendor Tuple Stream Parser

This block sits behind a walker that steps through a card's information tuple chain. The walker hands it one tuple body at a time as a byte stream. A start marker flags the first beat, and the tuple's declared length and its kind travel with that beat. The kind is either a vendor-specific tuple or a function-extension tuple. An end marker flags the last beat. The parser keeps the first bytes of the body and decides once, when the last beat arrives, what the tuple means.

For vendor tuples, byte 0 selects a subtype. Each subtype has its own set of lengths that are allowed. A tuple with a good length loads its board parameters into output registers and sets that field's valid bit. Multi-byte values are assembled little-endian. Some bytes are copied to several outputs: one antenna gain byte fills all eight per-band gain outputs, and the power-target and idle-signal bytes each fill both band outputs. A tuple with a bad length leaves every field as it was and sets a sticky error flag with the offending subtype code. A function-extension tuple that has the shape of a network node identifier loads a 48-bit node address. Any other function-extension tuple is dropped silently.

Top module: `vendor_tuple_parser`

## Requirements
- R1: After reset every captured field reads all-ones, except board_flags, which reads zero. field_valid, err_flag and err_code read zero.
- R2: A vendor tuple with subtype 1 and length 5 or 7 loads vendor_id = byte1 | byte2<<8 and sets field_valid[0].
- R3: Vendor tuples of length 2 load byte 1 into an output: subtype 2 into board_rev (field_valid[1]), subtype 5 into country (field_valid[3]), and subtype 6 into both bytes of ant_avail (field_valid[4]).
- R4: A subtype 7 tuple of length 2 writes byte 1 into all eight bytes of ant_gain and sets field_valid[5].
- R5: A subtype 3 tuple of length 9 or 10 loads pa_coef0/1/2 from byte pairs (1,2), (3,4), (5,6), each little-endian. Byte 7 goes to both bytes of idle_tgt and byte 8 to both bytes of max_pwr. It sets field_valid[2].
- R6: A subtype 8 tuple of length 3 or 5 loads board_flags = byte1 | byte2<<8 and sets field_valid[6].
- R7: A subtype 9 tuple of length 5 loads gpio_map with byte 1 in bits 7:0 through byte 4 in bits 31:24, and sets field_valid[7].
- R8: Vendor tuples with subtype 4 or any code outside 1..9 change no output and raise no error, whatever their length.
- R9: A vendor tuple of a known subtype (other than 4) whose length is outside its allowed set sets err_flag, records the subtype in err_code, and leaves all fields and field_valid unchanged. An empty vendor tuple (length 0, one beat, data ignored) sets the error with code 0.
- R10: err_flag stays set until reset, and err_code keeps the code of the first error. Later tuples with good lengths are still captured.
- R11: A function-extension tuple is accepted only when its length is 8, byte 0 is 0x04 and byte 1 is 6. It then loads node_addr with byte 2 in bits 47:40 through byte 7 in bits 7:0, and sets field_valid[8]. Any other such tuple changes nothing and raises no error.
- R12: Outputs change on the rising edge that samples the end beat, and not earlier. field_valid bits never clear except by reset.
- R13: Cycles with in_valid low between beats of one tuple are ignored and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Beat carries a body byte |
| in_sop | input | 1 | First beat of a tuple |
| in_eop | input | 1 | Last beat of a tuple |
| in_node | input | 1 | With in_sop: 1 = function-extension tuple, 0 = vendor tuple |
| in_len | input | 8 | With in_sop: declared body length |
| in_data | input | 8 | Body byte |
| vendor_id | output | 16 | Vendor identifier |
| board_rev | output | 8 | Board revision |
| country | output | 8 | Country code |
| ant_avail | output | 16 | Antenna availability, one byte per band |
| ant_gain | output | 64 | Eight per-band antenna gains |
| pa_coef0 | output | 16 | Power amplifier coefficient 0 |
| pa_coef1 | output | 16 | Power amplifier coefficient 1 |
| pa_coef2 | output | 16 | Power amplifier coefficient 2 |
| idle_tgt | output | 16 | Idle signal target, one byte per band |
| max_pwr | output | 16 | Maximum power, one byte per band |
| board_flags | output | 16 | Low board flags |
| gpio_map | output | 32 | Four GPIO assignments |
| node_addr | output | 48 | Network node address |
| field_valid | output | 9 | Per-field captured flags |
| err_flag | output | 1 | Sticky length error |
| err_code | output | 8 | Subtype of first length error |

## Verification
The bench targets these corner cases:
- Single-beat tuples, where start and end fall on the same beat. A design that read the length from a stored copy would check it against a stale value.
- Both allowed lengths of each two-length subtype, plus one length just outside the set. A wrong check either drops good tuples or captures bad ones with a corrupted field.
- Bodies longer than the stored window, name and unknown subtypes, and malformed node tuples. These must leave everything alone, and a parser that flagged them would set err_flag.
- Two errors in a row, with a good tuple after them. This exposes a code that is overwritten, a flag that clears, or capture that stops after the first error.

// File: rtl/vtp_pkg.sv
// Package: shared constants for the vendor tuple parser.
// Holds the subtype codes, the field_valid bit map and the permitted lengths.
package vtp_pkg;
    localparam int LEN_W      = 8;
    localparam int BODY_BYTES = 9;   // bytes 0..8 are all a decode ever needs
    localparam int FV_W       = 9;
    localparam int NUM_GAIN   = 8;
    localparam int NUM_BAND   = 2;

    typedef logic [LEN_W-1:0] len_t;

    // field_valid bit positions
    localparam int FV_ID   = 0;
    localparam int FV_BREV = 1;
    localparam int FV_PA   = 2;
    localparam int FV_CC   = 3;
    localparam int FV_ANT  = 4;
    localparam int FV_GAIN = 5;
    localparam int FV_BFL  = 6;
    localparam int FV_LED  = 7;
    localparam int FV_NODE = 8;

    // vendor subtype codes
    localparam logic [7:0] SUB_ID   = 8'd1;
    localparam logic [7:0] SUB_BREV = 8'd2;
    localparam logic [7:0] SUB_PA   = 8'd3;
    localparam logic [7:0] SUB_NAME = 8'd4;
    localparam logic [7:0] SUB_CC   = 8'd5;
    localparam logic [7:0] SUB_ANT  = 8'd6;
    localparam logic [7:0] SUB_GAIN = 8'd7;
    localparam logic [7:0] SUB_BFL  = 8'd8;
    localparam logic [7:0] SUB_LED  = 8'd9;

    // node identifier tuple shape
    localparam logic [7:0] NODE_TAG  = 8'h04;
    localparam logic [7:0] NODE_ALEN = 8'd6;
    localparam len_t       NODE_LEN  = len_t'(8);
endpackage

// File: rtl/vtp_collector.sv
// Module: vtp_collector
// Gathers the leading bytes of one tuple body into a window and presents a
// view in which the current beat is already merged, so that the decision
// can be made in the same cycle as the end beat.
// Assumes the walker sends at least one beat per tuple, and that in_len and
// in_node are valid on the start beat. Bytes past the window are dropped.
module vtp_collector #(
    parameter int BUF_BYTES = vtp_pkg::BODY_BYTES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_sop,
    input  logic                        in_eop,
    input  logic                        in_node,
    input  vtp_pkg::len_t               in_len,
    input  logic [7:0]                  in_data,
    output logic [BUF_BYTES-1:0][7:0]   view,
    output vtp_pkg::len_t               cur_len,
    output logic                        cur_node,
    output logic                        done
);
    localparam int IW = $clog2(BUF_BYTES + 1);
    localparam logic [IW-1:0] IDX_SAT = IW'(BUF_BYTES);

    logic [BUF_BYTES-1:0][7:0] win_q;
    logic [IW-1:0]             idx_q;
    logic [IW-1:0]             cur_idx;
    vtp_pkg::len_t             len_q;
    logic                      node_q;

    // Position of the present beat within its tuple, plus the header fields
    // taken live on the start beat and from storage afterwards.
    always_comb begin
        cur_idx  = in_sop ? '0 : idx_q;
        cur_len  = in_sop ? in_len : len_q;
        cur_node = in_sop ? in_node : node_q;
        done     = in_valid && in_eop;
    end

    // Window view with the present beat bypassed into its slot.
    always_comb begin
        for (int i = 0; i < BUF_BYTES; i++) begin
            view[i] = (in_valid && cur_idx == IW'(i)) ? in_data : win_q[i];
        end
    end

    // Store beats and advance the saturating byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= '0;
            idx_q  <= '0;
            len_q  <= '0;
            node_q <= 1'b0;
        end else if (in_valid) begin
            if (cur_idx < IDX_SAT) begin
                win_q[cur_idx] <= in_data;
                idx_q          <= cur_idx + 1'b1;
            end else begin
                idx_q          <= cur_idx;
            end
            if (in_sop) begin
                len_q  <= in_len;
                node_q <= in_node;
            end
        end
    end
endmodule

// File: rtl/vtp_decoder.sv
// Module: vtp_decoder
// Pure combinational decision for a completed tuple. It raises one update
// strobe when the length fits the subtype, or an error strobe with a code
// when it does not. Name and unknown subtypes and rejected node tuples
// produce neither.
// Assumes code and byte1 are the merged view from the collector.
module vtp_decoder (
    input  logic                        done,
    input  logic                        is_node,
    input  vtp_pkg::len_t               len,
    input  logic [7:0]                  code,
    input  logic [7:0]                  byte1,
    output logic [vtp_pkg::FV_W-1:0]    upd,
    output logic                        err_set,
    output logic [7:0]                  err_val
);
    import vtp_pkg::*;

    logic len_ok;
    int   slot;

    // Select the permitted length set and target field for the subtype.
    always_comb begin
        len_ok = 1'b0;
        slot   = -1;
        unique case (code)
            SUB_ID:   begin slot = FV_ID;   len_ok = (len == len_t'(5)) || (len == len_t'(7)); end
            SUB_BREV: begin slot = FV_BREV; len_ok = (len == len_t'(2)); end
            SUB_PA:   begin slot = FV_PA;   len_ok = (len == len_t'(9)) || (len == len_t'(10)); end
            SUB_CC:   begin slot = FV_CC;   len_ok = (len == len_t'(2)); end
            SUB_ANT:  begin slot = FV_ANT;  len_ok = (len == len_t'(2)); end
            SUB_GAIN: begin slot = FV_GAIN; len_ok = (len == len_t'(2)); end
            SUB_BFL:  begin slot = FV_BFL;  len_ok = (len == len_t'(3)) || (len == len_t'(5)); end
            SUB_LED:  begin slot = FV_LED;  len_ok = (len == len_t'(5)); end
            default:  begin slot = -1;      len_ok = 1'b0; end
        endcase
    end

    // Turn the decision into update and error strobes.
    always_comb begin
        upd     = '0;
        err_set = 1'b0;
        err_val = code;
        if (done) begin
            if (is_node) begin
                if (code == NODE_TAG && byte1 == NODE_ALEN && len == NODE_LEN)
                    upd[FV_NODE] = 1'b1;
            end else if (len == '0) begin
                err_set = 1'b1;
                err_val = 8'h00;
            end else if (slot >= 0) begin
                if (len_ok) upd[slot] = 1'b1;
                else        err_set   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vtp_field_store.sv
// Module: vtp_field_store
// Output registers for every captured field. Each is loaded from the tuple
// bytes when its update strobe fires. Replicated outputs are kept as
// separate registers, one per copy.
// Assumes bt[k] holds body byte k of the tuple that just ended.
module vtp_field_store #(
    parameter int NUM_GAIN = vtp_pkg::NUM_GAIN,
    parameter int NUM_BAND = vtp_pkg::NUM_BAND
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [vtp_pkg::FV_W-1:0]    upd,
    input  logic [8:1][7:0]             bt,
    output logic [15:0]                 vendor_id,
    output logic [7:0]                  board_rev,
    output logic [7:0]                  country,
    output logic [NUM_BAND*8-1:0]       ant_avail,
    output logic [NUM_GAIN*8-1:0]       ant_gain,
    output logic [15:0]                 pa_coef0,
    output logic [15:0]                 pa_coef1,
    output logic [15:0]                 pa_coef2,
    output logic [NUM_BAND*8-1:0]       idle_tgt,
    output logic [NUM_BAND*8-1:0]       max_pwr,
    output logic [15:0]                 board_flags,
    output logic [31:0]                 gpio_map,
    output logic [47:0]                 node_addr
);
    import vtp_pkg::*;

    // Single-copy fields, little-endian assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vendor_id   <= '1;
            board_rev   <= '1;
            country     <= '1;
            pa_coef0    <= '1;
            pa_coef1    <= '1;
            pa_coef2    <= '1;
            board_flags <= '0;
            gpio_map    <= '1;
            node_addr   <= '1;
        end else begin
            if (upd[FV_ID])   vendor_id <= {bt[2], bt[1]};
            if (upd[FV_BREV]) board_rev <= bt[1];
            if (upd[FV_CC])   country   <= bt[1];
            if (upd[FV_PA]) begin
                pa_coef0 <= {bt[2], bt[1]};
                pa_coef1 <= {bt[4], bt[3]};
                pa_coef2 <= {bt[6], bt[5]};
            end
            if (upd[FV_BFL])  board_flags <= {bt[2], bt[1]};
            if (upd[FV_LED])  gpio_map    <= {bt[4], bt[3], bt[2], bt[1]};
            if (upd[FV_NODE]) node_addr   <= {bt[2], bt[3], bt[4], bt[5], bt[6], bt[7]};
        end
    end

    // One gain register per band-antenna slot.
    for (genvar g = 0; g < NUM_GAIN; g++) begin : g_gain
        // Load the shared gain byte into this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)             ant_gain[g*8 +: 8] <= '1;
            else if (upd[FV_GAIN])  ant_gain[g*8 +: 8] <= bt[1];
        end
    end

    // Per-band copies of the antenna, idle target and power bytes.
    for (genvar b = 0; b < NUM_BAND; b++) begin : g_band
        // Load this band's copies.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ant_avail[b*8 +: 8] <= '1;
                idle_tgt[b*8 +: 8]  <= '1;
                max_pwr[b*8 +: 8]   <= '1;
            end else begin
                if (upd[FV_ANT]) ant_avail[b*8 +: 8] <= bt[1];
                if (upd[FV_PA]) begin
                    idle_tgt[b*8 +: 8] <= bt[7];
                    max_pwr[b*8 +: 8]  <= bt[8];
                end
            end
        end
    end
endmodule

// File: rtl/vendor_tuple_parser.sv
// Module: vendor_tuple_parser (top)
// Streaming parser for vendor and node-identifier tuple bodies. The
// collector windows the bytes, the decoder rules on the tuple at its end
// beat, and the field store captures the values. This module keeps the
// valid bits and the sticky error record.
// Assumes one tuple at a time, each with its start beat first.
module vendor_tuple_parser #(
    parameter int BUF_BYTES = vtp_pkg::BODY_BYTES,
    parameter int NUM_GAIN  = vtp_pkg::NUM_GAIN,
    parameter int NUM_BAND  = vtp_pkg::NUM_BAND
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic                        in_sop,
    input  logic                        in_eop,
    input  logic                        in_node,
    input  logic [7:0]                  in_len,
    input  logic [7:0]                  in_data,
    output logic [15:0]                 vendor_id,
    output logic [7:0]                  board_rev,
    output logic [7:0]                  country,
    output logic [NUM_BAND*8-1:0]       ant_avail,
    output logic [NUM_GAIN*8-1:0]       ant_gain,
    output logic [15:0]                 pa_coef0,
    output logic [15:0]                 pa_coef1,
    output logic [15:0]                 pa_coef2,
    output logic [NUM_BAND*8-1:0]       idle_tgt,
    output logic [NUM_BAND*8-1:0]       max_pwr,
    output logic [15:0]                 board_flags,
    output logic [31:0]                 gpio_map,
    output logic [47:0]                 node_addr,
    output logic [vtp_pkg::FV_W-1:0]    field_valid,
    output logic                        err_flag,
    output logic [7:0]                  err_code
);
    logic [BUF_BYTES-1:0][7:0]   view;
    vtp_pkg::len_t               cur_len;
    logic                        cur_node;
    logic                        done;
    logic [vtp_pkg::FV_W-1:0]    dec_upd;
    logic                        dec_err;
    logic [7:0]                  dec_code;

    vtp_collector #(.BUF_BYTES(BUF_BYTES)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .in_node  (in_node),
        .in_len   (in_len),
        .in_data  (in_data),
        .view     (view),
        .cur_len  (cur_len),
        .cur_node (cur_node),
        .done     (done)
    );

    vtp_decoder u_decode (
        .done    (done),
        .is_node (cur_node),
        .len     (cur_len),
        .code    (view[0]),
        .byte1   (view[1]),
        .upd     (dec_upd),
        .err_set (dec_err),
        .err_val (dec_code)
    );

    vtp_field_store #(.NUM_GAIN(NUM_GAIN), .NUM_BAND(NUM_BAND)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd         (dec_upd),
        .bt          (view[BUF_BYTES-1:1]),
        .vendor_id   (vendor_id),
        .board_rev   (board_rev),
        .country     (country),
        .ant_avail   (ant_avail),
        .ant_gain    (ant_gain),
        .pa_coef0    (pa_coef0),
        .pa_coef1    (pa_coef1),
        .pa_coef2    (pa_coef2),
        .idle_tgt    (idle_tgt),
        .max_pwr     (max_pwr),
        .board_flags (board_flags),
        .gpio_map    (gpio_map),
        .node_addr   (node_addr)
    );

    // Accumulate the per-field valid bits.
    always_ff @(posedge clk) begin
        if (!rst_n) field_valid <= '0;
        else        field_valid <= field_valid | dec_upd;
    end

    // Sticky error flag; the code of the first error is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_code <= '0;
        end else if (dec_err) begin
            err_flag <= 1'b1;
            if (!err_flag) err_code <= dec_code;
        end
    end
endmodule

// File: rtl/vtp_checker.sv
// Module: vtp_checker
// Temporal properties of the parser, attached to the top module by bind.
module vtp_checker #(
    parameter int NUM_GAIN = vtp_pkg::NUM_GAIN,
    parameter int NUM_BAND = vtp_pkg::NUM_BAND
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [vtp_pkg::FV_W-1:0]    field_valid,
    input logic                        err_flag,
    input logic [7:0]                  err_code,
    input logic [15:0]                 board_flags,
    input logic [NUM_GAIN*8-1:0]       ant_gain,
    input logic [NUM_BAND*8-1:0]       ant_avail,
    input logic [NUM_BAND*8-1:0]       idle_tgt,
    input logic [NUM_BAND*8-1:0]       max_pwr,
    input logic                        dec_err
);
    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> (err_flag && $stable(err_code)));

    // R12
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((field_valid & $past(field_valid)) == $past(field_valid)));

    // R9
    err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |=> $stable(field_valid));

    // R6
    flags_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !field_valid[vtp_pkg::FV_BFL] |-> (board_flags == 16'h0000));

    for (genvar g = 1; g < NUM_GAIN; g++) begin : g_gain
        // R4
        gain_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ant_gain[g*8 +: 8] == ant_gain[7:0]);
    end

    for (genvar b = 1; b < NUM_BAND; b++) begin : g_band
        // R5
        band_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (idle_tgt[b*8 +: 8] == idle_tgt[7:0]) && (max_pwr[b*8 +: 8] == max_pwr[7:0]));
        // R3
        ant_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ant_avail[b*8 +: 8] == ant_avail[7:0]);
    end
endmodule

bind vendor_tuple_parser vtp_checker #(.NUM_GAIN(NUM_GAIN), .NUM_BAND(NUM_BAND)) u_vtp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_valid (field_valid),
    .err_flag    (err_flag),
    .err_code    (err_code),
    .board_flags (board_flags),
    .ant_gain    (ant_gain),
    .ant_avail   (ant_avail),
    .idle_tgt    (idle_tgt),
    .max_pwr     (max_pwr),
    .dec_err     (dec_err)
);

// File: tb/test_vendor_tuple_parser.sv
// Bench: drives tuples and compares every output against a behavioural
// model on each falling clock edge.
module test_vendor_tuple_parser;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_node = 1'b0;
    logic [7:0]  in_len = '0, in_data = '0;
    logic [15:0] vendor_id, pa_coef0, pa_coef1, pa_coef2, idle_tgt, max_pwr, board_flags, ant_avail;
    logic [7:0]  board_rev, country, err_code;
    logic [63:0] ant_gain;
    logic [31:0] gpio_map;
    logic [47:0] node_addr;
    logic [8:0]  field_valid;
    logic        err_flag;

    vendor_tuple_parser i_vendor_tuple_parser (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
        .in_node(in_node), .in_len(in_len), .in_data(in_data),
        .vendor_id(vendor_id), .board_rev(board_rev), .country(country), .ant_avail(ant_avail),
        .ant_gain(ant_gain), .pa_coef0(pa_coef0), .pa_coef1(pa_coef1), .pa_coef2(pa_coef2),
        .idle_tgt(idle_tgt), .max_pwr(max_pwr), .board_flags(board_flags), .gpio_map(gpio_map),
        .node_addr(node_addr), .field_valid(field_valid), .err_flag(err_flag), .err_code(err_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;
    logic [7:0] q[$];

    // reference model state
    logic [15:0] e_vid, e_pa0, e_pa1, e_pa2, e_bfl;
    logic [7:0]  e_brev, e_cc, e_ant, e_gain, e_itssi, e_maxp, e_code;
    logic [31:0] e_gpio;
    logic [47:0] e_node;
    logic [8:0]  e_valid;
    logic        e_err;

    task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s act %h exp %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        e_vid = '1; e_pa0 = '1; e_pa1 = '1; e_pa2 = '1; e_bfl = '0;
        e_brev = '1; e_cc = '1; e_ant = '1; e_gain = '1; e_itssi = '1; e_maxp = '1;
        e_gpio = '1; e_node = '1; e_valid = '0; e_err = 1'b0; e_code = '0;
    endtask

    task automatic model_err(input logic [7:0] c);
        if (!e_err) e_code = c;
        e_err = 1'b1;
    endtask

    // apply one finished tuple to the model, from the requirements
    task automatic model_apply(input bit node, input int len);
        if (node) begin
            if (len == 8 && q[0] == 8'h04 && q[1] == 8'd6) begin
                e_node = {q[2], q[3], q[4], q[5], q[6], q[7]};
                e_valid[8] = 1'b1;
            end
        end else if (len == 0) begin
            model_err(8'h00);
        end else begin
            case (q[0])
                8'd1: if (len == 5 || len == 7) begin e_vid = {q[2], q[1]}; e_valid[0] = 1'b1; end else model_err(q[0]);
                8'd2: if (len == 2) begin e_brev = q[1]; e_valid[1] = 1'b1; end else model_err(q[0]);
                8'd3: if (len == 9 || len == 10) begin
                          e_pa0 = {q[2], q[1]}; e_pa1 = {q[4], q[3]}; e_pa2 = {q[6], q[5]};
                          e_itssi = q[7]; e_maxp = q[8]; e_valid[2] = 1'b1;
                      end else model_err(q[0]);
                8'd5: if (len == 2) begin e_cc = q[1]; e_valid[3] = 1'b1; end else model_err(q[0]);
                8'd6: if (len == 2) begin e_ant = q[1]; e_valid[4] = 1'b1; end else model_err(q[0]);
                8'd7: if (len == 2) begin e_gain = q[1]; e_valid[5] = 1'b1; end else model_err(q[0]);
                8'd8: if (len == 3 || len == 5) begin e_bfl = {q[2], q[1]}; e_valid[6] = 1'b1; end else model_err(q[0]);
                8'd9: if (len == 5) begin e_gpio = {q[4], q[3], q[2], q[1]}; e_valid[7] = 1'b1; end else model_err(q[0]);
                default: ;
            endcase
        end
    endtask

    // send the bytes in q as one tuple; gap idle cycles between beats
    task automatic send(input bit node, input int gap);
        int len = q.size();
        int beats = (len < 1) ? 1 : len;
        for (int k = 0; k < beats; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = (k == 0); in_eop = (k == beats - 1);
            in_node = node; in_len = 8'(len);
            in_data = (k < len) ? q[k] : 8'h5a;
            @(posedge clk);
            if (k == beats - 1) model_apply(node, len);
            if (gap > 0 && k != beats - 1) begin
                @(negedge clk);
                in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = 8'hee;
                for (int j = 1; j < gap; j++) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        cmp_en = 1'b0; rst_n = 1'b0; in_valid = 1'b0;
        repeat (4) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        cmp_en = 1'b1;
    endtask

    // per-cycle comparison of every output with the model
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            cmp("R2",  "vendor_id",   vendor_id, e_vid);
            cmp("R3",  "board_rev",   board_rev, e_brev);
            cmp("R3",  "country",     country, e_cc);
            cmp("R3",  "ant_avail",   ant_avail, {2{e_ant}});
            cmp("R4",  "ant_gain",    ant_gain, {8{e_gain}});
            cmp("R5",  "pa_coefs",    {pa_coef2, pa_coef1, pa_coef0}, {e_pa2, e_pa1, e_pa0});
            cmp("R5",  "tgt_pwr",     {idle_tgt, max_pwr}, {{2{e_itssi}}, {2{e_maxp}}});
            cmp("R6",  "board_flags", board_flags, e_bfl);
            cmp("R7",  "gpio_map",    gpio_map, e_gpio);
            cmp("R11", "node_addr",   node_addr, e_node);
            cmp("R12", "field_valid", field_valid, e_valid);
            cmp("R9",  "err_flag",    err_flag, e_err);
            cmp("R10", "err_code",    err_code, e_code);
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            finished = 1'b1;
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        @(negedge clk);
        // R1 reset state
        cmp("R1", "field_valid", field_valid, 9'h000);
        cmp("R1", "err", {err_flag, err_code}, 9'h000);
        cmp("R1", "board_flags", board_flags, 16'h0000);
        cmp("R1", "vendor_id", vendor_id, 16'hffff);
        cmp("R1", "node_addr", node_addr, 48'hffff_ffff_ffff);
        cmp("R1", "ant_gain", ant_gain, 64'hffff_ffff_ffff_ffff);

        q = '{8'h01, 8'h34, 8'h12, 8'haa, 8'hbb};                      send(1'b0, 0);
        cmp("R2", "vendor_id len5", vendor_id, 16'h1234);
        q = '{8'h02, 8'h5a};                                           send(1'b0, 0);
        q = '{8'h05, 8'h21};                                           send(1'b0, 0);
        q = '{8'h06, 8'h03};                                           send(1'b0, 0);
        q = '{8'h07, 8'h0c};                                           send(1'b0, 0);
        cmp("R4", "ant_gain", ant_gain, 64'h0c0c_0c0c_0c0c_0c0c);
        q = '{8'h03, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h88}; send(1'b0, 0);
        cmp("R5", "pa_coef1", pa_coef1, 16'h4433);
        q = '{8'h03, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09}; send(1'b0, 0);
        cmp("R5", "max_pwr len10", max_pwr, 16'h0808);
        q = '{8'h08, 8'hab, 8'hcd};                                    send(1'b0, 0);
        cmp("R6", "board_flags len3", board_flags, 16'hcdab);
        q = '{8'h08, 8'h01, 8'h02, 8'h03, 8'h04};                      send(1'b0, 0);
        q = '{8'h09, 8'ha1, 8'hb2, 8'hc3, 8'hd4};                      send(1'b0, 0);
        cmp("R7", "gpio_map", gpio_map, 32'hd4c3_b2a1);

        // R8 name and unknown subtypes, one longer than the window
        q = '{8'h04, 8'h41, 8'h42};                                    send(1'b0, 0);
        q = '{8'h0b, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0a, 8'h0b}; send(1'b0, 0);
        q = '{8'h00, 8'h77};                                           send(1'b0, 0);
        cmp("R8", "err after ignored", {err_flag, err_code}, 9'h000);
        cmp("R8", "board_rev kept", board_rev, 8'h5a);

        // R11 node identifier: good one, then three malformed ones
        q = '{8'h04, 8'h06, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55}; send(1'b1, 0);
        cmp("R11", "node_addr", node_addr, 48'h0011_2233_4455);
        q = '{8'h04, 8'h05, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99}; send(1'b1, 0);
        q = '{8'h03, 8'h06, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99}; send(1'b1, 0);
        q = '{8'h04, 8'h06, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99};        send(1'b1, 0);
        cmp("R11", "rejected node", {err_flag, node_addr}, {1'b0, 48'h0011_2233_4455});

        // R13 ID length 7 with idle gaps between beats
        q = '{8'h01, 8'hef, 8'hbe, 8'h01, 8'h02, 8'h03, 8'h04};        send(1'b0, 2);
        cmp("R13", "vendor_id gapped", vendor_id, 16'hbeef);

        // R9 / R10 errors
        q = '{8'h01, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99};               send(1'b0, 0);
        cmp("R9", "err after bad id", {err_flag, err_code}, {1'b1, 8'h01});
        cmp("R9", "vendor_id kept", vendor_id, 16'hbeef);
        q = '{8'h02, 8'h99, 8'h99};                                    send(1'b0, 0);
        q = '{8'h03, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99, 8'h99}; send(1'b0, 0);
        cmp("R10", "first code kept", err_code, 8'h01);
        q = '{8'h06, 8'h0f};                                           send(1'b0, 0);
        cmp("R10", "capture after err", ant_avail, 16'h0f0f);

        // R9 empty tuple after a fresh reset
        do_reset();
        @(negedge clk);
        cmp("R1", "second reset", {field_valid, err_flag}, 10'h000);
        q = {};                                                        send(1'b0, 0);
        cmp("R9", "empty tuple", {err_flag, err_code}, {1'b1, 8'h00});
        q = '{8'h09, 8'h01, 8'h02, 8'h03};                             send(1'b0, 0);
        cmp("R9", "bad led kept", {field_valid, gpio_map}, {9'h000, 32'hffff_ffff});

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule